// File: doc/BRIEF.md
# Pre-encoded radix-4 signed-digit multiplier

This block multiplies a signed two's-complement operand by a coefficient that was recoded ahead of time into a compact radix-4 signed-digit form. Because the recoding is already done, the block has no on-line Booth recoder. It turns each stored digit field straight into the select signals for one partial-product row. All rows are weighted by powers of four and compressed into one sum row and one carry row, together with a row that restores the +1 of every negated row. A parallel-prefix carry-lookahead adder then merges the two rows, and the product is registered.

The lower digits take only the values -2, -1, 0 and +1, so each needs just two stored bits. The most significant digit can reach +2. It therefore keeps a three-bit sign/one/two Booth field, which gives a word of COEF_W+1 bits for a COEF_W-bit coefficient. One coefficient and one operand can be presented on every clock cycle.

Top module: `presd_mult`

## Requirements
- R1: For each lower digit j (0 <= j < COEF_W/2-1), bits [2j+1:2j] of `coef_in` encode the digit value -2*bit(2j+1) + bit(2j), weighted by 4^j.
- R2: The top digit field uses bit COEF_W (negate), bit COEF_W-1 (two) and bit COEF_W-2 (one). Its magnitude is 2 when `two` is set, else 1 when `one` is set, else 0. The value is negated when the negate bit is set, and it is weighted by 4^(COEF_W/2-1).
- R3: `prod` equals the exact signed product of `a_in` and the decoded coefficient, as a PROD_W = A_W+COEF_W bit two's-complement value.
- R4: `vld_out` is high in the cycle after each cycle with `vld_in` high, and low in the cycle after a cycle with `vld_in` low. `prod` updates at that same edge.
- R5: When `vld_in` is low, `prod` keeps its previous value.
- R6: A synchronous active-high `rst` clears `vld_out` and `prod` to zero at the next clock edge.
- R7: The most negative operand and the most negative or most positive coefficient give exact products without wrap-around.
- R8: A top digit with the negate bit set and zero magnitude contributes nothing to the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_in | input | 1 | Operand and coefficient valid strobe |
| a_in | input | A_W | Signed multiplicand |
| coef_in | input | COEF_W+1 | Pre-encoded coefficient word |
| vld_out | output | 1 | Product valid, one cycle after `vld_in` |
| prod | output | A_W+COEF_W | Registered signed product |

## Verification
On every cycle, the bound checker compares the registered product against a reference product that it decodes from the previous cycle's ports. The same checker follows the one-cycle valid relation, holds the product on idle cycles, clears both outputs after reset, and forces a zero product for an all-zero coefficient. The bench scenarios add three things the per-cycle properties cannot cover by themselves. They steer stimulus into the extreme corners: most negative operand, most negative and most positive coefficient, and negated-zero top digit. They apply a reset that lands right after a valid input. They exercise a broad random spread of digit patterns across the array.

// File: rtl/presd_pkg.sv
package presd_pkg;

  // Select signals of one partial-product row
  typedef struct packed {
    logic neg;   // invert the row and add one through the correction row
    logic one;   // select the operand
    logic two;   // select the operand shifted left by one
  } pp_sel_t;

endpackage

// File: rtl/presd_digit_decode.sv
module presd_digit_decode
  import presd_pkg::*;
#(
  parameter int COEF_W = 16,
  localparam int DIGITS = COEF_W / 2,
  localparam int ENC_W  = COEF_W + 1
) (
  input  logic [ENC_W-1:0]           enc,
  output pp_sel_t [DIGITS-1:0]       sel
);

  // Lower digits: two stored bits, digit set {-2,-1,0,+1}
  for (genvar j = 0; j < DIGITS - 1; j++) begin : g_low
    logic hi, lo;
    assign hi = enc[2*j+1];
    assign lo = enc[2*j];
    assign sel[j].neg = hi;
    assign sel[j].one = lo;
    assign sel[j].two = hi & ~lo;
  end

  // Top digit: stored Booth field, digit set {-2..+2}, two has priority
  logic top_neg, top_two, top_one;
  assign top_neg = enc[COEF_W];
  assign top_two = enc[COEF_W-1];
  assign top_one = enc[COEF_W-2];

  assign sel[DIGITS-1].neg = top_neg;
  assign sel[DIGITS-1].two = top_two;
  assign sel[DIGITS-1].one = top_one & ~top_two;

endmodule

// File: rtl/presd_pp_row.sv
module presd_pp_row
  import presd_pkg::*;
#(
  parameter int A_W    = 17,
  parameter int PROD_W = 33,
  parameter int SHIFT  = 0
) (
  input  logic [A_W-1:0]    a,
  input  pp_sel_t           sel,
  output logic [PROD_W-1:0] row
);

  logic [PROD_W-1:0] a_ext;
  logic [PROD_W-1:0] mag;
  logic [PROD_W-1:0] flipped;

  assign a_ext = {{(PROD_W-A_W){a[A_W-1]}}, a};

  always_comb begin
    if (sel.two)
      mag = a_ext << 1;
    else if (sel.one)
      mag = a_ext;
    else
      mag = '0;
  end

  // Ones' complement here; the +1 rides in the correction row
  assign flipped = mag ^ {PROD_W{sel.neg}};
  assign row     = flipped << SHIFT;

endmodule

// File: rtl/presd_csa_array.sv
module presd_csa_array #(
  parameter int ROWS   = 9,
  parameter int PROD_W = 33
) (
  input  logic [ROWS-1:0][PROD_W-1:0] rows,
  output logic [PROD_W-1:0]           sum_row,
  output logic [PROD_W-1:0]           carry_row
);

  localparam int STAGES = ROWS - 1;

  logic [STAGES-1:0][PROD_W-1:0] s_st;
  logic [STAGES-1:0][PROD_W-1:0] c_st;

  assign s_st[0] = rows[0];
  assign c_st[0] = rows[1];

  // Each 3:2 stage folds one more row into the redundant pair
  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    logic [PROD_W-1:0] x, y, z;
    assign x = s_st[i-1];
    assign y = c_st[i-1];
    assign z = rows[i+1];
    assign s_st[i] = x ^ y ^ z;
    assign c_st[i] = ((x & y) | (x & z) | (y & z)) << 1;
  end

  assign sum_row   = s_st[STAGES-1];
  assign carry_row = c_st[STAGES-1];

endmodule

// File: rtl/presd_cla.sv
module presd_cla #(
  parameter int W = 33,
  localparam int LV = $clog2(W)
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);

  logic [LV:0][W-1:0] gen;
  logic [LV:0][W-1:0] prp;

  assign gen[0] = x & y;
  assign prp[0] = x ^ y;

  // Parallel-prefix lookahead: each level doubles the span
  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int D = 1 << l;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_comb
        assign gen[l+1][i] = gen[l][i] | (prp[l][i] & gen[l][i-D]);
        assign prp[l+1][i] = prp[l][i] & prp[l][i-D];
      end else begin : g_pass
        assign gen[l+1][i] = gen[l][i];
        assign prp[l+1][i] = prp[l][i];
      end
    end
  end

  assign s = prp[0] ^ {gen[LV][W-2:0], 1'b0};

endmodule

// File: rtl/presd_mult.sv
module presd_mult
  import presd_pkg::*;
#(
  parameter int A_W    = 17,
  parameter int COEF_W = 16,
  localparam int DIGITS = COEF_W / 2,
  localparam int ENC_W  = COEF_W + 1,
  localparam int PROD_W = A_W + COEF_W,
  localparam int ROWS   = DIGITS + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld_in,
  input  logic [A_W-1:0]       a_in,
  input  logic [ENC_W-1:0]     coef_in,
  output logic                 vld_out,
  output logic [PROD_W-1:0]    prod
);

  pp_sel_t [DIGITS-1:0]          sel;
  logic [ROWS-1:0][PROD_W-1:0]   rows;
  logic [PROD_W-1:0]             corr;
  logic [PROD_W-1:0]             sum_row, carry_row, result;

  presd_digit_decode #(.COEF_W(COEF_W)) u_dec (
    .enc (coef_in),
    .sel (sel)
  );

  for (genvar j = 0; j < DIGITS; j++) begin : g_pp
    presd_pp_row #(.A_W(A_W), .PROD_W(PROD_W), .SHIFT(2*j)) u_row (
      .a   (a_in),
      .sel (sel[j]),
      .row (rows[j])
    );
  end

  // Correction row: one +1 at the weight of every negated row
  always_comb begin
    corr = '0;
    for (int j = 0; j < DIGITS; j++)
      corr[2*j] = sel[j].neg;
  end
  assign rows[ROWS-1] = corr;

  presd_csa_array #(.ROWS(ROWS), .PROD_W(PROD_W)) u_csa (
    .rows      (rows),
    .sum_row   (sum_row),
    .carry_row (carry_row)
  );

  presd_cla #(.W(PROD_W)) u_cla (
    .x (sum_row),
    .y (carry_row),
    .s (result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_out <= 1'b0;
      prod    <= '0;
    end else begin
      vld_out <= vld_in;
      if (vld_in)
        prod <= result;
    end
  end

endmodule

// File: rtl/presd_mult_chk.sv
module presd_mult_chk #(
  parameter int A_W    = 17,
  parameter int COEF_W = 16,
  localparam int DIGITS = COEF_W / 2,
  localparam int ENC_W  = COEF_W + 1,
  localparam int PROD_W = A_W + COEF_W
) (
  input logic              clk,
  input logic              rst,
  input logic              vld_in,
  input logic [A_W-1:0]    a_in,
  input logic [ENC_W-1:0]  coef_in,
  input logic              vld_out,
  input logic [PROD_W-1:0] prod
);

  // Reference product built digit by digit from the stored field
  logic signed [PROD_W-1:0] ref_prod;
  logic signed [PROD_W-1:0] coef_val;
  logic signed [PROD_W-1:0] a_val;

  always_comb begin
    coef_val = '0;
    for (int j = 0; j < DIGITS - 1; j++) begin
      if (coef_in[2*j+1]) coef_val = coef_val - (PROD_W'(2) << (2*j));
      if (coef_in[2*j])   coef_val = coef_val + (PROD_W'(1) << (2*j));
    end
    begin
      logic signed [PROD_W-1:0] top;
      top = coef_in[COEF_W-1] ? PROD_W'(2) : (coef_in[COEF_W-2] ? PROD_W'(1) : '0);
      if (coef_in[COEF_W]) top = -top;
      coef_val = coef_val + (top <<< (2*(DIGITS-1)));
    end
    a_val    = PROD_W'($signed(a_in));
    ref_prod = a_val * coef_val;
  end

  // R3
  product_value_chk: assert property (@(posedge clk) disable iff (rst)
    vld_in |=> (prod == $past(ref_prod)));

  // R4
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    vld_in |=> vld_out);

  // R4
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_in |=> !vld_out);

  // R5
  prod_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_in |=> $stable(prod));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!vld_out && prod == '0));

  // R8
  zero_coef_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_in && coef_val == '0) |=> (prod == '0));

endmodule

bind presd_mult presd_mult_chk #(.A_W(A_W), .COEF_W(COEF_W)) u_presd_mult_chk (
  .clk     (clk),
  .rst     (rst),
  .vld_in  (vld_in),
  .a_in    (a_in),
  .coef_in (coef_in),
  .vld_out (vld_out),
  .prod    (prod)
);

// File: tb/presd_mult_test.sv
module presd_mult_test;

  localparam int A_W    = 17;
  localparam int COEF_W = 16;
  localparam int DIGITS = COEF_W / 2;
  localparam int ENC_W  = COEF_W + 1;
  localparam int PROD_W = A_W + COEF_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              vld_in = 1'b0;
  logic [A_W-1:0]    a_in = '0;
  logic [ENC_W-1:0]  coef_in = '0;
  logic              vld_out;
  logic [PROD_W-1:0] prod;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  presd_mult #(.A_W(A_W), .COEF_W(COEF_W)) uut (
    .clk     (clk),
    .rst     (rst),
    .vld_in  (vld_in),
    .a_in    (a_in),
    .coef_in (coef_in),
    .vld_out (vld_out),
    .prod    (prod)
  );

  // Coefficient value from the field layout of R1 and R2
  function automatic longint coef_value(input logic [ENC_W-1:0] c);
    longint v = 0;
    longint mag;
    for (int j = 0; j < DIGITS - 1; j++)
      v += (-2 * longint'(c[2*j+1]) + longint'(c[2*j])) * (longint'(1) << (2*j));
    mag = c[COEF_W-1] ? 2 : (c[COEF_W-2] ? 1 : 0);
    if (c[COEF_W]) mag = -mag;
    v += mag * (longint'(1) << (2*(DIGITS-1)));
    return v;
  endfunction

  function automatic logic [PROD_W-1:0] expect_prod(input logic [A_W-1:0] a,
                                                    input logic [ENC_W-1:0] c);
    longint p;
    p = longint'($signed(a)) * coef_value(c);
    return p[PROD_W-1:0];
  endfunction

  task automatic check_val(input string req, input logic [PROD_W-1:0] act,
                           input logic [PROD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Present one pair for one cycle, then check the registered result
  task automatic apply(input logic [A_W-1:0] a, input logic [ENC_W-1:0] c,
                       input string req);
    logic [PROD_W-1:0] exp;
    exp = expect_prod(a, c);
    @(negedge clk);
    a_in = a; coef_in = c; vld_in = 1'b1;
    @(negedge clk);
    vld_in = 1'b0;
    a_in = ~a; coef_in = ~c;
    check_bit({req, " vld_out"}, vld_out, 1'b1);
    check_val(req, prod, exp);
  endtask

  logic [ENC_W-1:0] c_min, c_max, c_nz;
  logic [A_W-1:0]   a_min, a_max;

  initial begin
    void'($urandom(32'd2024));
    for (int j = 0; j < DIGITS - 1; j++) begin
      c_min[2*j+1 -: 2] = 2'b10;
      c_max[2*j+1 -: 2] = 2'b01;
      c_nz[2*j+1 -: 2]  = 2'b00;
    end
    c_min[COEF_W -: 3] = 3'b110;
    c_max[COEF_W -: 3] = 3'b010;
    c_nz[COEF_W -: 3]  = 3'b100;
    a_min = {1'b1, {(A_W-1){1'b0}}};
    a_max = {1'b0, {(A_W-1){1'b1}}};

    // R6: reset state
    repeat (3) @(negedge clk);
    check_bit("R6 reset vld_out", vld_out, 1'b0);
    check_val("R6 reset prod", prod, '0);
    rst = 1'b0;

    // R1: single lower digits in isolation
    for (int j = 0; j < DIGITS - 1; j++) begin
      for (int d = 1; d < 4; d++) begin
        logic [ENC_W-1:0] c = '0;
        c[2*j+1 -: 2] = 2'(d);
        apply(17'd3, c, "R1");
      end
    end
    // R2: every top-field pattern, including one+two together
    for (int t = 0; t < 8; t++) begin
      logic [ENC_W-1:0] c = '0;
      c[COEF_W -: 3] = 3'(t);
      apply(17'h1abcd, c, "R2");
    end
    // R7: extreme corners
    apply(a_min, c_min, "R7 minA minB");
    apply(a_min, c_max, "R7 minA maxB");
    apply(a_max, c_min, "R7 maxA minB");
    apply(a_max, c_max, "R7 maxA maxB");
    // R8: negated zero top digit, alone and with lower digits
    apply(a_min, c_nz, "R8 neg zero");
    apply(17'h0f0f1, c_nz | 17'h00026, "R8 neg zero mixed");

    // R5: output holds while idle with inputs changing
    begin
      logic [PROD_W-1:0] held;
      held = prod;
      @(negedge clk);
      a_in = 17'h15555; coef_in = c_min;
      @(negedge clk);
      check_bit("R4 idle vld_out", vld_out, 1'b0);
      check_val("R5 hold", prod, held);
    end

    // R3/R4: random stream, back-to-back and with gaps
    for (int i = 0; i < 400; i++) begin
      logic [A_W-1:0]   a = A_W'($urandom);
      logic [ENC_W-1:0] c = ENC_W'($urandom);
      if (i % 3 == 0) begin
        apply(a, c, "R3 random");
      end else begin
        logic [PROD_W-1:0] exp = expect_prod(a, c);
        @(negedge clk);
        a_in = a; coef_in = c; vld_in = 1'b1;
        @(negedge clk);
        vld_in = (i % 2 == 0);
        check_bit("R4 stream vld_out", vld_out, 1'b1);
        check_val("R3 stream", prod, exp);
      end
    end
    @(negedge clk); vld_in = 1'b0;
    @(negedge clk);

    // R6: reset right after a valid input
    @(negedge clk);
    a_in = a_max; coef_in = c_max; vld_in = 1'b1;
    @(negedge clk);
    vld_in = 1'b0; rst = 1'b1;
    @(negedge clk);
    check_bit("R6 mid reset vld_out", vld_out, 1'b0);
    check_val("R6 mid reset prod", prod, '0);
    rst = 1'b0;
    apply(17'h00007, c_max, "R3 after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule